// File: doc/BRIEF.md
# Five-State Input-Steered Sequence Machine

This block is a small synchronous controller with five legal states held in a three-bit register. Each state's binary code is the position of its letter in the alphabet, counting from zero, so A is 000 and E is 100. A single input `x` chooses between two branches out of each of the first three states. D and E always fall back to A. The single output `z` marks arrival in E. The state register is also brought out so that neighbouring logic can observe it.

Two elaboration parameters pick how the hardware is built. `NEXT_STYLE` chooses the next-state logic:

- `0` uses a one-hot decode of the four bits {state, x} into sixteen lines, and each next-state bit is the OR of the lines that set it.
- `1` uses hand-minimized sum-of-products equations.

`Z_MEALY` chooses whether `z` is taken from the state bits alone or from the decoded {state, x} lines. Every combination of the two parameters must give the same cycle-by-cycle behaviour.

Top module: `seqfsm_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes A (000) after that edge, and `z` is 0 there.
- R2: From A (000), `x`=0 leads to B (001) and `x`=1 leads to C (010) at the next edge.
- R3: From B (001), `x`=0 leads to D (011) and `x`=1 leads to E (100) at the next edge.
- R4: From C (010), `x`=0 leads to E (100) and `x`=1 leads to D (011) at the next edge.
- R5: From D (011) and from E (100), the next edge returns to A (000) whatever `x` is.
- R6: `z` is 1 exactly when the state is E (100), and 0 in every other state.
- R7: With `Z_MEALY`=1, `z` is taken from the {state, x} decode, and it equals the value the state-only form gives for both values of `x`.
- R8: After reset, `state` only ever shows one of the five codes 000, 001, 010, 011 or 100.
- R9: The decode-based and minimized next-state styles produce the same `state` and `z` in every cycle when they are given the same `x` sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Steering input that selects the branch |
| z | output | 1 | High while the machine is in E |
| state | output | 3 | Current state code, s2 is the most significant bit |

## Verification
The assertions check on every cycle that each transition taken from a legal state lands on the code the graph requires, that a reset edge leaves the machine in A, that `z` is high only in E, and that the register never holds an unused code. The bench's scenarios are needed to show that the two next-state styles and the two output forms stay in step over long random `x` sequences. They also show that every one of the ten edges of the graph is actually taken, and that a reset applied in the middle of a sequence takes effect.

// File: rtl/seqfsm_pkg.sv
package seqfsm_pkg;

    localparam int STATE_W   = 3;
    localparam int DEC_IN_W  = STATE_W + 1;
    localparam int DEC_LINES = 2 ** DEC_IN_W;

    typedef enum logic [STATE_W-1:0] {
        ST_A = 3'd0,
        ST_B = 3'd1,
        ST_C = 3'd2,
        ST_D = 3'd3,
        ST_E = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic [STATE_W-1:0] state;
    } seq_regs_t;

    // Target state for one decoder line; the line index is {state, x}, x in bit 0.
    function automatic logic [STATE_W-1:0] line_next(input logic [DEC_IN_W-1:0] idx);
        logic [STATE_W-1:0] cur;
        logic               xb;
        cur = idx[DEC_IN_W-1:1];
        xb  = idx[0];
        case (cur)
            ST_A:    line_next = xb ? ST_C : ST_B;
            ST_B:    line_next = xb ? ST_E : ST_D;
            ST_C:    line_next = xb ? ST_D : ST_E;
            default: line_next = ST_A;
        endcase
    endfunction

    // Output value carried by one decoder line.
    function automatic logic line_z(input logic [DEC_IN_W-1:0] idx);
        line_z = (idx[DEC_IN_W-1:1] == ST_E);
    endfunction

endpackage

// File: rtl/seqfsm_dec_next.sv
module seqfsm_dec_next
    import seqfsm_pkg::*;
(
    input  logic [STATE_W-1:0] cur_state,
    input  logic               x,
    output logic [STATE_W-1:0] nxt_state
);

    logic [DEC_LINES-1:0] line;

    // one-hot decode of {state, x}
    genvar gi;
    generate
        for (gi = 0; gi < DEC_LINES; gi++) begin : g_line
            assign line[gi] = ({cur_state, x} == DEC_IN_W'(gi));
        end
    endgenerate

    // each next-state bit is the OR of the lines that set it
    always_comb begin
        nxt_state = '0;
        for (int i = 0; i < DEC_LINES; i++) begin
            nxt_state = nxt_state | ({STATE_W{line[i]}} & line_next(DEC_IN_W'(i)));
        end
    end

endmodule

// File: rtl/seqfsm_sop_next.sv
module seqfsm_sop_next
    import seqfsm_pkg::*;
(
    input  logic [STATE_W-1:0] cur_state,
    input  logic               x,
    output logic [STATE_W-1:0] nxt_state
);

    logic s2, s1, s0;

    always_comb begin
        {s2, s1, s0} = cur_state;
        // reaching E: B with x=1, or C with x=0
        nxt_state[2] = (~s2 & ~s1 &  s0 &  x) | (~s2 & s1 & ~s0 & ~x);
        // reaching C or D: A with x=1, B with x=0, C with x=1
        nxt_state[1] = (~s2 & ~s1 & (s0 ^ x)) | (~s2 & s1 & ~s0 & x);
        // reaching B or D: A or B with x=0, C with x=1
        nxt_state[0] = (~s2 & ~s1 & ~x) | (~s2 & s1 & ~s0 & x);
    end

endmodule

// File: rtl/seqfsm_zout.sv
module seqfsm_zout
    import seqfsm_pkg::*;
#(
    parameter bit MEALY = 1'b0
) (
    input  logic [STATE_W-1:0] cur_state,
    input  logic               x,
    output logic               z
);

    logic z_state_only;
    logic z_decoded;

    always_comb begin
        z_state_only = (cur_state == ST_E);
        z_decoded    = 1'b0;
        for (int i = 0; i < DEC_LINES; i++) begin
            if ({cur_state, x} == DEC_IN_W'(i)) begin
                z_decoded = z_decoded | line_z(DEC_IN_W'(i));
            end
        end
    end

    assign z = MEALY ? z_decoded : z_state_only;

endmodule

// File: rtl/seqfsm_top.sv
module seqfsm_top
    import seqfsm_pkg::*;
#(
    parameter int NEXT_STYLE = 0,
    parameter bit Z_MEALY    = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               x,
    output logic               z,
    output logic [STATE_W-1:0] state
);

    seq_regs_t          regs_d, regs_q;
    logic [STATE_W-1:0] nxt_state;

    generate
        if (NEXT_STYLE == 0) begin : g_decode
            seqfsm_dec_next u_next (
                .cur_state (regs_q.state),
                .x         (x),
                .nxt_state (nxt_state)
            );
        end else begin : g_sop
            seqfsm_sop_next u_next (
                .cur_state (regs_q.state),
                .x         (x),
                .nxt_state (nxt_state)
            );
        end
    endgenerate

    seqfsm_zout #(.MEALY(Z_MEALY)) u_zout (
        .cur_state (regs_q.state),
        .x         (x),
        .z         (z)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.state = ST_A;
        end else begin
            regs_d.state = nxt_state;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state = regs_q.state;

    // R1
    reset_to_a_chk: assert property (@(posedge clk) rst |=> (state == ST_A && !z));

    // R2
    from_a_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_A) |=> (state == ($past(x) ? ST_C : ST_B)));

    // R3
    from_b_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_B) |=> (state == ($past(x) ? ST_E : ST_D)));

    // R4
    from_c_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_C) |=> (state == ($past(x) ? ST_D : ST_E)));

    // R5
    return_a_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_D || state == ST_E) |=> (state == ST_A));

    // R6
    z_in_e_only_chk: assert property (@(posedge clk) disable iff (rst)
        z == (state == ST_E));

    // R8
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        !state[2] || (state[1:0] == 2'b00));

endmodule

// File: tb/seqfsm_top_bench.sv
module seqfsm_top_bench;
    import seqfsm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_STEPS = 3000;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       x   = 1'b0;
    logic       z_dec, z_sop, z_mly;
    logic [2:0] st_dec, st_sop, st_mly;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [2:0] ref_s = 3'd0;
    bit         cov [5][2];

    always #(CLK_PERIOD/2) clk = ~clk;

    seqfsm_top #(.NEXT_STYLE(0), .Z_MEALY(1'b0)) u_seqfsm_top (
        .clk(clk), .rst(rst), .x(x), .z(z_dec), .state(st_dec));
    seqfsm_top #(.NEXT_STYLE(1), .Z_MEALY(1'b0)) u_seqfsm_top_sop (
        .clk(clk), .rst(rst), .x(x), .z(z_sop), .state(st_sop));
    seqfsm_top #(.NEXT_STYLE(1), .Z_MEALY(1'b1)) u_seqfsm_top_mly (
        .clk(clk), .rst(rst), .x(x), .z(z_mly), .state(st_mly));

    function automatic logic [2:0] ref_next(input logic [2:0] s, input logic xb);
        case (s)
            3'd0:    return xb ? 3'd2 : 3'd1;
            3'd1:    return xb ? 3'd4 : 3'd3;
            3'd2:    return xb ? 3'd3 : 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic ref_z(input logic [2:0] s);
        return s == 3'd4;
    endfunction

    function automatic string req_of(input logic [2:0] s);
        case (s)
            3'd0:    return "R2";
            3'd1:    return "R3";
            3'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare all instances with the model; called after x has settled
    task automatic check_all(input string req);
        check(req, "state decode", st_dec, ref_s);
        check("R9", "state minimized", st_sop, ref_s);
        check("R9", "state mealy build", st_mly, ref_s);
        check("R6", "z moore decode", z_dec, ref_z(ref_s));
        check("R9", "z moore minimized", z_sop, ref_z(ref_s));
        check("R7", "z mealy", z_mly, ref_z(ref_s));
        check("R8", "legal code", (st_dec <= 3'd4) ? 1 : 0, 1);
    endtask

    // called at a falling edge: apply x, check, advance one edge
    task automatic step(input logic xv, input string req);
        logic [2:0] prev;
        x = xv;
        #1;
        check_all(req);
        prev = ref_s;
        @(posedge clk);
        if (rst) begin
            ref_s = 3'd0;
        end else begin
            if (prev <= 3'd4) cov[prev][xv] = 1'b1;
            ref_s = ref_next(prev, xv);
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1729));
        rst = 1'b1;
        x   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ref_s = 3'd0;
        // R1: reset state
        check("R1", "state after reset", st_dec, 0);
        check("R1", "z after reset", z_dec, 0);
        rst = 1'b0;

        // directed walks through every branch
        step(1'b1, "R2"); // A -> C
        step(1'b0, "R4"); // C -> E
        step(1'b0, "R5"); // E, x=0 -> A  (R7 with x=0)
        step(1'b0, "R2"); // A -> B
        step(1'b1, "R3"); // B -> E
        step(1'b1, "R5"); // E, x=1 -> A  (R7 with x=1)
        step(1'b1, "R2"); // A -> C
        step(1'b1, "R4"); // C -> D
        step(1'b1, "R5"); // D, x=1 -> A
        step(1'b0, "R2"); // A -> B
        step(1'b0, "R3"); // B -> D
        step(1'b0, "R5"); // D, x=0 -> A

        // R1: reset in mid-sequence, from B
        step(1'b0, "R2");
        rst = 1'b1;
        step(1'b1, "R1");
        rst = 1'b0;
        check("R1", "state after mid reset", st_dec, 0);
        check("R1", "z after mid reset", z_dec, 0);

        // random x sequences with occasional reset
        for (int i = 0; i < RAND_STEPS; i++) begin
            rst = (($urandom % 97) == 0);
            step(1'($urandom % 2), rst ? "R1" : req_of(ref_s));
            rst = 1'b0;
        end
        step(1'b0, "R8");

        // every edge of the graph taken
        for (int s = 0; s < 5; s++) begin
            for (int b = 0; b < 2; b++) begin
                check(req_of(3'(s)), $sformatf("edge from %0d with x=%0d taken", s, b),
                      cov[s][b] ? 1 : 0, 1);
            end
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule